// File: doc/BRIEF.md
# Daisy-Chained Interrupt Priority Chain

This block arbitrates interrupt requests from several devices by passing a single acknowledge through a chain of stages, one stage per device. Each device raises its request as a rising edge. The stage for that device holds the request in a flag. The flags together drive a single interrupt line to the processor.

When the processor raises its acknowledge, the signal enters stage 0, which has the highest priority. A stage with no pending flag passes the acknowledge on to the next stage. The first stage that holds a pending flag absorbs the acknowledge, places its own vector on a shared vector bus, and blocks every stage after it. The vector bus is zero when no stage is granted.

A granted stage keeps its grant for a fixed number of clock cycles and then clears its own flag. If the acknowledge is still high, the grant then moves on to the next pending stage. A stage that loses the acknowledge to a stage ahead of it keeps its flag and is serviced later. Stage vectors are a base value plus a fixed step times the stage index.

Top module: `irq_daisy_chain`

## Requirements
- R1: `int_req` is high exactly when at least one bit of `pending` is set.
- R2: A rising edge on `dev_req[i]` sets `pending[i]` at the next clock edge. A level held high sets the flag only once, so after the flag is serviced it stays clear while the input remains high.
- R3: `int_ack` enters stage 0. A stage whose priority input is high and whose flag is set is granted: it drives its priority output low and places its vector on `vec_bus`.
- R4: A stage whose priority input is high and whose flag is clear passes the acknowledge on. At most one stage is granted, and it is the lowest-index stage with a set flag.
- R5: A stage whose priority input is low drives its priority output low and keeps its vector off the bus. `chain_out`, the priority output of the last stage, is high only when `int_ack` is high and no flag is set.
- R6: A granted stage clears its flag after CLR_DELAY consecutive clock edges at which it is granted. The grant then moves to the next pending stage.
- R7: A flag that is not granted is never cleared. If the grant is lost before CLR_DELAY edges, the service count restarts from zero and the flag stays set.
- R8: `vec_bus` is zero when no stage is granted. Stage i drives VEC_BASE + i*VEC_STEP, truncated to VEC_W bits.
- R9: A rising edge on `dev_req[i]` at the same clock edge that would clear `pending[i]` leaves the flag set.
- R10: While `rst_n` is low, all flags and service counts are cleared, so `pending` is 0 and `int_req` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dev_req | input | N_STAGES | Device requests; a rising edge sets the matching flag |
| int_ack | input | 1 | Processor acknowledge; the priority input of stage 0 |
| int_req | output | 1 | OR of all pending flags |
| vec_bus | output | VEC_W | Vector of the granted stage, or zero |
| chain_out | output | 1 | Priority output of the last stage |
| pending | output | N_STAGES | Request flags, bit i for stage i |

## Verification
The hardest situation to reach is a request rising in the very cycle its stage is being cleared. A second hard one is a lower stage that loses its grant partway through its service count. The stimulus reaches the first by holding the acknowledge for exactly CLR_DELAY-1 edges and then raising the device input just before the final edge. It reaches the second in two ways: by dropping the acknowledge early, and by raising a higher-priority request while a lower stage is being serviced. A sweep over all request patterns of a four-stage chain compares every output, in every cycle, against a behavioural model kept in the bench.

// File: rtl/irq_chain_pkg.sv
package irq_chain_pkg;

  // Vector assigned to one stage: base plus index times step.
  function automatic logic [31:0] stage_vector(input logic [31:0] base,
                                               input logic [31:0] step,
                                               input int          idx);
    return base + step * 32'(idx);
  endfunction

  // Width of a counter that counts 0 .. delay-1.
  function automatic int cnt_width(input int delay);
    return (delay > 1) ? $clog2(delay) : 1;
  endfunction

endpackage

// File: rtl/irq_req_flag.sv
module irq_req_flag #(
  parameter int CLR_DELAY = 3,
  parameter int CNT_W     = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dev_req,
  input  logic granted,
  output logic flag
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CLR_DELAY - 1);

  logic             req_q;
  logic [CNT_W-1:0] svc_cnt;
  logic             set_evt;
  logic             svc_done;

  assign set_evt  = dev_req & ~req_q;
  assign svc_done = granted && (svc_cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q   <= 1'b0;
      flag    <= 1'b0;
      svc_cnt <= '0;
    end else begin
      req_q <= dev_req;
      if (set_evt)       flag <= 1'b1;
      else if (svc_done) flag <= 1'b0;
      if (granted && !svc_done) svc_cnt <= svc_cnt + 1'b1;
      else                      svc_cnt <= '0;
    end
  end

  p_rise_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |=> flag);
  p_preempt_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !granted) |=> flag);
  p_delay_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_done && !set_evt) |=> !flag);
  p_rise_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_done && set_evt) |=> flag);
  p_count_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    svc_cnt <= LAST);

endmodule

// File: rtl/irq_chain_stage.sv
module irq_chain_stage #(
  parameter int               VEC_W = 8,
  parameter logic [VEC_W-1:0] VEC   = '0
) (
  input  logic             prio_in,
  input  logic             pending,
  output logic             prio_out,
  output logic             granted,
  output logic [VEC_W-1:0] vec_out
);
  assign granted  = prio_in & pending;
  assign prio_out = prio_in & ~pending;
  assign vec_out  = granted ? VEC : '0;
endmodule

// File: rtl/irq_vec_merge.sv
module irq_vec_merge #(
  parameter int N_STAGES = 4,
  parameter int VEC_W    = 8
) (
  input  logic [N_STAGES*VEC_W-1:0] vec_flat,
  output logic [VEC_W-1:0]          vec_bus
);
  always_comb begin
    vec_bus = '0;
    for (int i = 0; i < N_STAGES; i++) vec_bus |= vec_flat[i*VEC_W +: VEC_W];
  end
endmodule

// File: rtl/irq_daisy_chain.sv
module irq_daisy_chain
  import irq_chain_pkg::*;
#(
  parameter int          N_STAGES  = 4,
  parameter int          VEC_W     = 8,
  parameter logic [31:0] VEC_BASE  = 32'h40,
  parameter logic [31:0] VEC_STEP  = 32'h4,
  parameter int          CLR_DELAY = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N_STAGES-1:0] dev_req,
  input  logic                int_ack,
  output logic                int_req,
  output logic [VEC_W-1:0]    vec_bus,
  output logic                chain_out,
  output logic [N_STAGES-1:0] pending
);
  localparam int CNT_W = cnt_width(CLR_DELAY);

  logic [N_STAGES:0]         prio;
  logic [N_STAGES-1:0]       grant;
  logic [N_STAGES*VEC_W-1:0] vec_flat;

  assign prio[0] = int_ack;

  for (genvar gi = 0; gi < N_STAGES; gi++) begin : g_stage
    localparam logic [VEC_W-1:0] STAGE_VEC =
      VEC_W'(stage_vector(VEC_BASE, VEC_STEP, gi));

    irq_req_flag #(.CLR_DELAY(CLR_DELAY), .CNT_W(CNT_W)) u_flag (
      .clk     (clk),
      .rst_n   (rst_n),
      .dev_req (dev_req[gi]),
      .granted (grant[gi]),
      .flag    (pending[gi])
    );

    irq_chain_stage #(.VEC_W(VEC_W), .VEC(STAGE_VEC)) u_stage (
      .prio_in  (prio[gi]),
      .pending  (pending[gi]),
      .prio_out (prio[gi+1]),
      .granted  (grant[gi]),
      .vec_out  (vec_flat[gi*VEC_W +: VEC_W])
    );

    p_chain_cut_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !prio[gi] |-> (!prio[gi+1] && !grant[gi]));

    if (gi > 0) begin : g_first
      p_grant_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
        grant[gi] |-> (pending[gi-1:0] == '0));
    end
  end

  irq_vec_merge #(.N_STAGES(N_STAGES), .VEC_W(VEC_W)) u_merge (
    .vec_flat (vec_flat),
    .vec_bus  (vec_bus)
  );

  assign int_req   = |pending;
  assign chain_out = prio[N_STAGES];

  p_single_grant_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  p_idle_vec_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (grant == '0) |-> (vec_bus == '0));
  p_no_ack_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !int_ack |-> (grant == '0 && !chain_out));
  p_ack_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (int_ack && int_req) |-> (grant != '0 && !chain_out));

endmodule

// File: tb/tb_irq_daisy_chain.sv
module tb_irq_daisy_chain;
  localparam int          CLK_PERIOD = 10;
  localparam int          N          = 4;
  localparam int          VW         = 8;
  localparam logic [31:0] BASE       = 32'h40;
  localparam logic [31:0] STEP       = 32'h4;
  localparam int          DLY        = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  dev_req = '0;
  logic          int_ack = 1'b0;
  logic          int_req;
  logic [VW-1:0] vec_bus;
  logic          chain_out;
  logic [N-1:0]  pending;

  int checks = 0;
  int errors = 0;

  irq_daisy_chain #(.N_STAGES(N), .VEC_W(VW), .VEC_BASE(BASE),
                    .VEC_STEP(STEP), .CLR_DELAY(DLY)) dut (
    .clk(clk), .rst_n(rst_n), .dev_req(dev_req), .int_ack(int_ack),
    .int_req(int_req), .vec_bus(vec_bus), .chain_out(chain_out),
    .pending(pending)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Behavioural model built from the requirements.
  logic [N-1:0] m_flag;
  logic [N-1:0] m_prev;
  int           m_cnt [N];
  int           m_g;
  logic         m_rise;
  logic         m_last;

  function automatic int first_pending(input logic [N-1:0] f, input logic ack);
    if (!ack) return -1;
    for (int i = 0; i < N; i++) if (f[i]) return i;
    return -1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_flag = '0;
      m_prev = '0;
      for (int i = 0; i < N; i++) m_cnt[i] = 0;
    end else begin
      m_g = first_pending(m_flag, int_ack);
      for (int i = 0; i < N; i++) begin
        m_rise = dev_req[i] & ~m_prev[i];
        m_last = (m_g == i) && (m_cnt[i] == DLY - 1);
        if (m_g == i) m_cnt[i] = m_last ? 0 : m_cnt[i] + 1;
        else          m_cnt[i] = 0;
        if (m_rise)      m_flag[i] = 1'b1;
        else if (m_last) m_flag[i] = 1'b0;
      end
      m_prev = dev_req;
    end
  end

  task automatic check_eq(input string req, input string what,
                          input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compare_all(input string req);
    int g;
    logic [VW-1:0] ev;
    g  = first_pending(m_flag, int_ack);
    ev = (g < 0) ? '0 : VW'(BASE + STEP * 32'(g));
    check_eq("R1", "int_req", 32'(int_req), 32'(|m_flag));
    check_eq(req, "pending", 32'(pending), 32'(m_flag));
    check_eq("R8", "vec_bus", 32'(vec_bus), 32'(ev));
    check_eq("R5", "chain_out", 32'(chain_out), 32'(int_ack && (m_flag == '0)));
  endtask

  task automatic tick(input string req);
    @(posedge clk);
    @(negedge clk);
    compare_all(req);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R10: reset state
    repeat (3) @(negedge clk);
    check_eq("R10", "pending in reset", 32'(pending), 0);
    check_eq("R10", "int_req in reset", 32'(int_req), 0);
    rst_n = 1'b1;
    tick("R10");

    // R5: acknowledge with nothing pending passes the whole chain
    int_ack = 1'b1;
    tick("R5");
    check_eq("R5", "chain_out idle ack", 32'(chain_out), 1);
    check_eq("R8", "vec_bus idle ack", 32'(vec_bus), 0);
    int_ack = 1'b0;
    tick("R5");

    // Sweep every request pattern: set, partial service, full service
    for (int p = 0; p < (1 << N); p++) begin
      dev_req = N'(p);
      tick("R2");
      dev_req = '0;
      check_eq("R2", "pattern set", 32'(pending), 32'(p));
      int_ack = 1'b1;
      for (int c = 0; c < DLY - 1; c++) tick("R3");
      int_ack = 1'b0;
      tick("R7");
      check_eq("R7", "after early drop", 32'(pending), 32'(p));
      int_ack = 1'b1;
      for (int c = 0; c < N * DLY + 1; c++) tick("R6");
      check_eq("R6", "all serviced", 32'(pending), 0);
      int_ack = 1'b0;
      tick("R4");
    end

    // R7: higher-priority request pre-empts a stage mid-service
    dev_req = 4'b1000;
    tick("R2");
    dev_req = '0;
    int_ack = 1'b1;
    tick("R3");
    check_eq("R3", "stage3 vector", 32'(vec_bus), 32'(VW'(BASE + 3 * STEP)));
    dev_req = 4'b0001;
    tick("R7");
    dev_req = '0;
    check_eq("R4", "stage0 takes grant", 32'(vec_bus), 32'(VW'(BASE)));
    for (int c = 0; c < DLY; c++) tick("R7");
    check_eq("R7", "stage3 still pending", 32'(pending), 32'h8);
    for (int c = 0; c < DLY; c++) tick("R6");
    check_eq("R6", "stage3 cleared", 32'(pending), 0);
    int_ack = 1'b0;
    tick("R6");

    // R9: rise lands on the clearing edge
    dev_req = 4'b0100;
    tick("R2");
    dev_req = '0;
    int_ack = 1'b1;
    for (int c = 0; c < DLY - 1; c++) tick("R9");
    dev_req = 4'b0100;
    tick("R9");
    check_eq("R9", "flag kept", 32'(pending), 32'h4);
    dev_req = '0;
    for (int c = 0; c < DLY; c++) tick("R9");
    check_eq("R9", "flag cleared later", 32'(pending), 0);
    int_ack = 1'b0;
    tick("R9");

    // R2: held level does not re-set a serviced flag
    dev_req = 4'b0001;
    tick("R2");
    int_ack = 1'b1;
    for (int c = 0; c < DLY + 2; c++) tick("R2");
    check_eq("R2", "held level no reset", 32'(pending), 0);
    int_ack = 1'b0;
    dev_req = '0;
    tick("R2");

    // R10: reset mid-operation
    dev_req = 4'b1010;
    tick("R2");
    dev_req = '0;
    int_ack = 1'b1;
    tick("R3");
    rst_n = 1'b0;
    #1;
    check_eq("R10", "pending after reset", 32'(pending), 0);
    check_eq("R10", "int_req after reset", 32'(int_req), 0);
    int_ack = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    tick("R10");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule